// File: doc/BRIEF.md
# Flash Block Lock and OTP Protection Guard

This block sits between the command decoder of a flash device and its program/erase engine and decides, for each request, whether the array or a protection register may be changed. It holds one lock bit per erase block. Every lock bit comes out of reset set, and each one can be set or cleared alone with no delay. It also holds a bank of one-time-programmable protection registers, and two sticky lock bits that seal that bank. A single input bit stands for the program supply being below its lockout level. While that bit is high, every change to stored content is refused.

Requests arrive on a valid/ready channel and each one produces a single registered response: permit or deny. The response channel has its own valid/ready pair. A new request is taken only when the response slot is empty, or when the slot is being drained in the same cycle (`req_ready = !resp_valid || resp_ready`). A stalled response holds its value until it is taken. A deny also sets a sticky error flag for the status register. Two plain query ports show the lock state of any block and the content of any protection-register word, so that system software and the status path can observe them.

Top module: `prot_guard`

## Requirements
- R1: After reset, every block reads locked, `err_flag` is 0, `resp_valid` is 0, both `otp_lock` bits are 0 and every user protection word reads all ones.
- R2: Op 3'd0 sets and op 3'd1 clears the lock bit of block `req_blk` only, and is permitted. The change applies to the very next accepted request, and every other block keeps its state.
- R3: Program (op 3'd2) and erase (op 3'd3) of block `req_blk` are permitted only when that block is unlocked and `vpp_low` is 0.
- R4: While `vpp_low` is 1, ops 3'd2, 3'd3, 3'd4 and 3'd5 are denied and leave all stored state unchanged. Lock and unlock are still permitted.
- R5: A permitted protection-word program (op 3'd4, register `req_reg`, word `req_word`) stores old AND `req_data`, so a bit at 0 never returns to 1.
- R6: Words 0 to FACTORY_BITS/WORD_W-1 of register 0 always read the FACTORY_ID parameter (word 0 holds bits 15:0). Any program to them is denied.
- R7: Op 3'd5 sets `otp_lock[0]` when `req_data[0]` is 1 and `otp_lock[1]` when `req_data[1]` is 1. Neither bit ever clears. When `otp_lock[0]` is set, programs to the user words of register 0 are denied. When `otp_lock[1]` is set, programs to registers 1 and above are denied.
- R8: Every denied request sets `err_flag`. The flag stays set through later permitted requests until op 3'd6 (clear status), which is permitted and clears it.
- R9: A request accepted at a clock edge shows its response (`resp_valid` = 1) right after that edge. While `resp_valid` is 1 and `resp_ready` is 0, `req_ready` is 0 and `resp_permit` holds.
- R10: A block index at or above NUM_BLOCKS, or a register index above NUM_UREGS, is denied for every op that takes that index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 3 | Operation code |
| req_blk | input | BLK_W | Block index for lock, unlock, program, erase |
| req_reg | input | REG_IW | Protection register index |
| req_word | input | WIDX_W | 16-bit word within the register |
| req_data | input | WORD_W | Program data, or lock bits for op 3'd5 |
| vpp_low | input | 1 | Program supply at or below lockout level |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken |
| resp_permit | output | 1 | 1 = permitted, 0 = denied |
| err_flag | output | 1 | Sticky protection error |
| qry_blk | input | BLK_W | Block whose lock state is shown |
| qry_locked | output | 1 | Lock state of `qry_blk` (1 for out-of-range index) |
| rd_reg | input | REG_IW | Protection register to read |
| rd_word | input | WIDX_W | Word to read |
| rd_data | output | WORD_W | Content of the selected word |
| otp_lock | output | 2 | Protection-register lock bits |

## Verification
The bench builds the block with NUM_BLOCKS = 11, NUM_UREGS = 2 and its own 64-bit factory value. Because 11 is not a power of two, the 4-bit block index reaches the out-of-range values 11 to 15. With a 2-bit register index, register 3 lies past the last register. The small block count also lets the bench sweep every block at reset and walk both ends of the index range. Keeping 128-bit registers of 16-bit words keeps the real split of register 0 into a factory half and a user half.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [2:0] {
    OP_LOCK   = 3'd0,
    OP_UNLOCK = 3'd1,
    OP_PGM    = 3'd2,
    OP_ERASE  = 3'd3,
    OP_OTP    = 3'd4,
    OP_OTPLK  = 3'd5,
    OP_CLRSR  = 3'd6,
    OP_NOP    = 3'd7
  } prot_op_e;

  function automatic logic op_changes_content(input prot_op_e op);
    return (op == OP_PGM) || (op == OP_ERASE) || (op == OP_OTP) || (op == OP_OTPLK);
  endfunction
endpackage

// File: rtl/blk_lock_bank.sv
module blk_lock_bank #(
  parameter int NUM_BLOCKS = 259,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_lock,
  input  logic [BLK_W-1:0] wr_idx,
  input  logic [BLK_W-1:0] chk_idx,
  output logic             chk_locked,
  input  logic [BLK_W-1:0] qry_idx,
  output logic             qry_locked
);
  logic [NUM_BLOCKS-1:0] lock_q;

  for (genvar k = 0; k < NUM_BLOCKS; k++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst) lock_q[k] <= 1'b1;
      else if (wr_en && (wr_idx == BLK_W'(k))) lock_q[k] <= wr_lock;
    end

    // R2: a write to block k lands on exactly that bit
    a_r2_lock_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_idx == BLK_W'(k))) |=> (lock_q[k] == $past(wr_lock)));
    // R2: other blocks are left alone
    a_r2_others_kept: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (wr_idx == BLK_W'(k))) |=> $stable(lock_q[k]));
  end

  always_comb begin
    chk_locked = 1'b1;
    qry_locked = 1'b1;
    for (int k = 0; k < NUM_BLOCKS; k++) begin
      if (chk_idx == BLK_W'(k)) chk_locked = lock_q[k];
      if (qry_idx == BLK_W'(k)) qry_locked = lock_q[k];
    end
  end
endmodule

// File: rtl/otp_bank.sv
module otp_bank #(
  parameter int NUM_REGS      = 17,
  parameter int REG_BITS      = 128,
  parameter int WORD_W        = 16,
  parameter int FACTORY_WORDS = 4,
  parameter logic [FACTORY_WORDS*WORD_W-1:0] FACTORY_ID = '0,
  parameter int REG_IW        = $clog2(NUM_REGS),
  parameter int WIDX_W        = $clog2(REG_BITS / WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pgm_en,
  input  logic [REG_IW-1:0] pgm_reg,
  input  logic [WIDX_W-1:0] pgm_word,
  input  logic [WORD_W-1:0] pgm_data,
  input  logic              lk_en,
  input  logic [1:0]        lk_data,
  input  logic [REG_IW-1:0] rd_reg,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  output logic [1:0]        lock_q
);
  localparam int WPR   = REG_BITS / WORD_W;
  localparam int TOTAL = NUM_REGS * WPR;
  localparam int AW    = REG_IW + WIDX_W;

  logic [TOTAL-1:0][WORD_W-1:0] words;
  logic [AW-1:0] pgm_addr;
  logic [AW-1:0] rd_addr;

  assign pgm_addr = {pgm_reg, pgm_word};
  assign rd_addr  = {rd_reg, rd_word};

  for (genvar w = 0; w < TOTAL; w++) begin : g_word
    if (w < FACTORY_WORDS) begin : g_fact
      assign words[w] = FACTORY_ID[w*WORD_W +: WORD_W];
    end else begin : g_user
      always_ff @(posedge clk) begin
        if (rst) words[w] <= '1;
        else if (pgm_en && (pgm_addr == AW'(w))) words[w] <= words[w] & pgm_data;
      end
      // R5: a programmed zero never rises again
      a_r5_no_rise: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((words[w] & ~$past(words[w])) == '0));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 2'b00;
    else if (lk_en) lock_q <= lock_q | lk_data;
  end

  // R7: protection-register lock bits never fall
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~lock_q & $past(lock_q)) == 2'b00));

  always_comb begin
    rd_data = '1;
    for (int w = 0; w < TOTAL; w++) begin
      if (rd_addr == AW'(w)) rd_data = words[w];
    end
  end
endmodule

// File: rtl/prot_resp.sv
module prot_resp (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic permit,
  input  logic is_clr,
  input  logic resp_ready,
  output logic resp_valid,
  output logic resp_permit,
  output logic err_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_permit <= 1'b0;
    end else if (acc) begin
      resp_valid  <= 1'b1;
      resp_permit <= permit;
    end else if (resp_ready) begin
      resp_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_flag <= 1'b0;
    else if (acc && is_clr) err_flag <= 1'b0;
    else if (acc && !permit) err_flag <= 1'b1;
  end

  // R9: a stalled response keeps its value
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_permit)));
  // R8: error flag only drops on a clear-status request
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !(acc && is_clr)) |=> err_flag);
  // R8: every deny raises the flag
  a_r8_deny_sets: assert property (@(posedge clk) disable iff (rst)
    (acc && !permit) |=> (err_flag && !resp_permit));
endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_pkg::*;
#(
  parameter int NUM_BLOCKS   = 259,
  parameter int NUM_UREGS    = 16,
  parameter int REG_BITS     = 128,
  parameter int WORD_W       = 16,
  parameter int FACTORY_BITS = 64,
  parameter logic [FACTORY_BITS-1:0] FACTORY_ID = 64'h5A17_C3E9_0B6D_48F2,
  parameter int NUM_REGS     = NUM_UREGS + 1,
  parameter int BLK_W        = $clog2(NUM_BLOCKS),
  parameter int REG_IW       = $clog2(NUM_REGS),
  parameter int WIDX_W       = $clog2(REG_BITS / WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [REG_IW-1:0] req_reg,
  input  logic [WIDX_W-1:0] req_word,
  input  logic [WORD_W-1:0] req_data,
  input  logic              vpp_low,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_permit,
  output logic              err_flag,
  input  logic [BLK_W-1:0]  qry_blk,
  output logic              qry_locked,
  input  logic [REG_IW-1:0] rd_reg,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  output logic [1:0]        otp_lock
);
  localparam int FACTORY_WORDS = FACTORY_BITS / WORD_W;
  localparam logic [BLK_W:0]  NB_LIM  = (BLK_W + 1)'(NUM_BLOCKS);
  localparam logic [REG_IW:0] NR_LIM  = (REG_IW + 1)'(NUM_REGS);
  localparam logic [WIDX_W:0] FW_LIM  = (WIDX_W + 1)'(FACTORY_WORDS);

  prot_op_e op;
  logic acc, permit;
  logic blk_ok, reg_ok, reg0, fact_hit, reg_sealed, blk_locked;

  assign op        = prot_op_e'(req_op);
  assign req_ready = !resp_valid || resp_ready;
  assign acc       = req_valid && req_ready;

  assign blk_ok     = {1'b0, req_blk} < NB_LIM;
  assign reg_ok     = {1'b0, req_reg} < NR_LIM;
  assign reg0       = (req_reg == '0);
  assign fact_hit   = reg0 && ({1'b0, req_word} < FW_LIM);
  assign reg_sealed = reg0 ? otp_lock[0] : otp_lock[1];

  always_comb begin
    unique case (op)
      OP_LOCK, OP_UNLOCK: permit = blk_ok;
      OP_PGM, OP_ERASE:   permit = !vpp_low && blk_ok && !blk_locked;
      OP_OTP:             permit = !vpp_low && reg_ok && !fact_hit && !reg_sealed;
      OP_OTPLK:           permit = !vpp_low;
      default:            permit = 1'b1;
    endcase
  end

  blk_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_locks (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (acc && permit && ((op == OP_LOCK) || (op == OP_UNLOCK))),
    .wr_lock    (op == OP_LOCK),
    .wr_idx     (req_blk),
    .chk_idx    (req_blk),
    .chk_locked (blk_locked),
    .qry_idx    (qry_blk),
    .qry_locked (qry_locked)
  );

  otp_bank #(
    .NUM_REGS(NUM_REGS), .REG_BITS(REG_BITS), .WORD_W(WORD_W),
    .FACTORY_WORDS(FACTORY_WORDS), .FACTORY_ID(FACTORY_ID),
    .REG_IW(REG_IW), .WIDX_W(WIDX_W)
  ) u_otp (
    .clk      (clk),
    .rst      (rst),
    .pgm_en   (acc && permit && (op == OP_OTP)),
    .pgm_reg  (req_reg),
    .pgm_word (req_word),
    .pgm_data (req_data),
    .lk_en    (acc && permit && (op == OP_OTPLK)),
    .lk_data  (req_data[1:0]),
    .rd_reg   (rd_reg),
    .rd_word  (rd_word),
    .rd_data  (rd_data),
    .lock_q   (otp_lock)
  );

  prot_resp u_resp (
    .clk         (clk),
    .rst         (rst),
    .acc         (acc),
    .permit      (permit),
    .is_clr      (op == OP_CLRSR),
    .resp_ready  (resp_ready),
    .resp_valid  (resp_valid),
    .resp_permit (resp_permit),
    .err_flag    (err_flag)
  );

  // R4: supply lockout overrides every content change
  a_r4_lockout: assert property (@(posedge clk) disable iff (rst)
    (acc && vpp_low && op_changes_content(op)) |=> !resp_permit);
  // R3: a locked block is never programmed or erased
  a_r3_locked_deny: assert property (@(posedge clk) disable iff (rst)
    (acc && blk_locked && ((op == OP_PGM) || (op == OP_ERASE))) |=> !resp_permit);
  // R9: nothing is taken while a response waits
  a_r9_no_take: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |-> !req_ready);
  // R10: out-of-range block index refused
  a_r10_blk_range: assert property (@(posedge clk) disable iff (rst)
    (acc && !blk_ok && (op inside {OP_LOCK, OP_UNLOCK, OP_PGM, OP_ERASE})) |=> !resp_permit);
endmodule

// File: tb/sim_prot_guard.sv
`timescale 1ns/1ps
module sim_prot_guard;
  localparam int NB = 11;
  localparam int NU = 2;
  localparam int BW = $clog2(NB);
  localparam int RIW = $clog2(NU + 1);
  localparam int WIW = 3;
  localparam logic [63:0] FID = 64'hC0DE_5EED_1234_A5F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, resp_ready = 1'b1, vpp_low = 1'b0;
  logic [2:0] req_op = 3'd7;
  logic [BW-1:0] req_blk = '0, qry_blk = '0;
  logic [RIW-1:0] req_reg = '0, rd_reg = '0;
  logic [WIW-1:0] req_word = '0, rd_word = '0;
  logic [15:0] req_data = '0;
  logic req_ready, resp_valid, resp_permit, err_flag, qry_locked;
  logic [15:0] rd_data;
  logic [1:0] otp_lock;

  int n_cmp = 0, n_bad = 0;
  logic pm;

  always #2.5 clk = ~clk;

  prot_guard #(.NUM_BLOCKS(NB), .NUM_UREGS(NU), .FACTORY_ID(FID)) u0 (
    .clk, .rst, .req_valid, .req_ready, .req_op, .req_blk, .req_reg, .req_word,
    .req_data, .vpp_low, .resp_valid, .resp_ready, .resp_permit, .err_flag,
    .qry_blk, .qry_locked, .rd_reg, .rd_word, .rd_data, .otp_lock);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input int blk, input int rg, input int wd,
                      input logic [15:0] data, output logic permit);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_blk = BW'(blk);
    req_reg = RIW'(rg); req_word = WIW'(wd); req_data = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 resp_valid after accept", {63'd0, resp_valid}, 64'd1);
    permit = resp_permit;
  endtask

  function automatic logic [63:0] rd(input int rg, input int wd);
    rd_reg = RIW'(rg); rd_word = WIW'(wd);
    return 64'(rd_data);
  endfunction

  task automatic look(input int rg, input int wd, input logic [15:0] exp, input string tag);
    rd_reg = RIW'(rg); rd_word = WIW'(wd);
    #0.5;
    chk(tag, 64'(rd_data), 64'(exp));
  endtask

  task automatic blk_state(input int b, input logic exp, input string tag);
    qry_blk = BW'(b);
    #0.5;
    chk(tag, {63'd0, qry_locked}, {63'd0, exp});
  endtask

  task automatic t_reset;
    for (int b = 0; b < NB; b++) blk_state(b, 1'b1, "R1 block locked at reset");
    chk("R1 err_flag", {63'd0, err_flag}, 64'd0);
    chk("R1 resp_valid", {63'd0, resp_valid}, 64'd0);
    chk("R1 otp_lock", {62'd0, otp_lock}, 64'd0);
    for (int r = 0; r <= NU; r++)
      for (int w = (r == 0) ? 4 : 0; w < 8; w++) look(r, w, 16'hFFFF, "R1 user word erased");
  endtask

  task automatic t_blocks;
    send(3'd2, 3, 0, 0, 0, pm); chk("R3 program locked block", {63'd0, pm}, 64'd0);
    send(3'd6, 0, 0, 0, 0, pm);
    send(3'd1, 3, 0, 0, 0, pm); chk("R2 unlock permitted", {63'd0, pm}, 64'd1);
    send(3'd2, 3, 0, 0, 0, pm); chk("R2 no latency program", {63'd0, pm}, 64'd1);
    blk_state(3, 1'b0, "R2 block 3 unlocked");
    blk_state(2, 1'b1, "R2 block 2 untouched");
    blk_state(4, 1'b1, "R2 block 4 untouched");
    send(3'd3, 3, 0, 0, 0, pm); chk("R3 erase unlocked", {63'd0, pm}, 64'd1);
    send(3'd0, 3, 0, 0, 0, pm);
    send(3'd3, 3, 0, 0, 0, pm); chk("R2 relock takes effect", {63'd0, pm}, 64'd0);
    send(3'd1, NB - 1, 0, 0, 0, pm);
    send(3'd3, NB - 1, 0, 0, 0, pm); chk("R3 last block erase", {63'd0, pm}, 64'd1);
    send(3'd6, 0, 0, 0, 0, pm);
  endtask

  task automatic t_range;
    send(3'd1, NB + 1, 0, 0, 0, pm); chk("R10 unlock out of range", {63'd0, pm}, 64'd0);
    send(3'd2, 15, 0, 0, 0, pm); chk("R10 program out of range", {63'd0, pm}, 64'd0);
    send(3'd4, 0, 3, 0, 16'h0000, pm); chk("R10 register out of range", {63'd0, pm}, 64'd0);
    send(3'd6, 0, 0, 0, 0, pm);
  endtask

  task automatic t_lockout;
    send(3'd1, 5, 0, 0, 0, pm);
    vpp_low = 1'b1;
    send(3'd2, 5, 0, 0, 0, pm); chk("R4 program under lockout", {63'd0, pm}, 64'd0);
    send(3'd3, 5, 0, 0, 0, pm); chk("R4 erase under lockout", {63'd0, pm}, 64'd0);
    send(3'd4, 0, 1, 0, 16'h0000, pm); chk("R4 OTP under lockout", {63'd0, pm}, 64'd0);
    look(1, 0, 16'hFFFF, "R4 OTP word unchanged");
    send(3'd5, 0, 0, 0, 16'h0003, pm); chk("R4 OTP lock under lockout", {63'd0, pm}, 64'd0);
    chk("R4 otp_lock unchanged", {62'd0, otp_lock}, 64'd0);
    send(3'd1, 6, 0, 0, 0, pm); chk("R4 unlock still allowed", {63'd0, pm}, 64'd1);
    blk_state(6, 1'b0, "R4 block 6 unlocked");
    vpp_low = 1'b0;
    send(3'd2, 5, 0, 0, 0, pm); chk("R4 program after lockout", {63'd0, pm}, 64'd1);
    send(3'd6, 0, 0, 0, 0, pm);
  endtask

  task automatic t_otp;
    send(3'd4, 0, 1, 2, 16'hF0F0, pm); chk("R5 program permitted", {63'd0, pm}, 64'd1);
    look(1, 2, 16'hF0F0, "R5 first program");
    send(3'd4, 0, 1, 2, 16'h0FFF, pm); look(1, 2, 16'h00F0, "R5 AND accumulate");
    send(3'd4, 0, 1, 2, 16'hFFFF, pm); look(1, 2, 16'h00F0, "R5 zeros never rise");
    send(3'd4, 0, 0, 4, 16'h1234, pm); look(0, 4, 16'h1234, "R5 reg0 user word");
  endtask

  task automatic t_factory;
    send(3'd4, 0, 0, 0, 16'h0000, pm); chk("R6 factory program denied", {63'd0, pm}, 64'd0);
    for (int w = 0; w < 4; w++) look(0, w, FID[w*16 +: 16], "R6 factory content");
    send(3'd6, 0, 0, 0, 0, pm);
  endtask

  task automatic t_seal;
    send(3'd5, 0, 0, 0, 16'h0001, pm); chk("R7 seal permitted", {63'd0, pm}, 64'd1);
    chk("R7 lock bit 0 set", {62'd0, otp_lock}, 64'd1);
    send(3'd4, 0, 0, 5, 16'h0000, pm); chk("R7 reg0 sealed", {63'd0, pm}, 64'd0);
    look(0, 5, 16'hFFFF, "R7 reg0 word unchanged");
    send(3'd4, 0, 2, 0, 16'h7777, pm); chk("R7 reg2 still open", {63'd0, pm}, 64'd1);
    send(3'd5, 0, 0, 0, 16'h0002, pm);
    chk("R7 both locks set", {62'd0, otp_lock}, 64'd3);
    send(3'd4, 0, 2, 1, 16'h0000, pm); chk("R7 reg2 sealed", {63'd0, pm}, 64'd0);
    look(2, 1, 16'hFFFF, "R7 reg2 word unchanged");
    send(3'd5, 0, 0, 0, 16'h0000, pm);
    chk("R7 locks never clear", {62'd0, otp_lock}, 64'd3);
  endtask

  task automatic t_err;
    send(3'd6, 0, 0, 0, 0, pm); chk("R8 clear permitted", {63'd0, pm}, 64'd1);
    chk("R8 flag cleared", {63'd0, err_flag}, 64'd0);
    send(3'd2, 0, 0, 0, 0, pm); chk("R8 deny sets flag", {63'd0, err_flag}, 64'd1);
    send(3'd0, 0, 0, 0, 0, pm); chk("R8 flag holds after permit", {63'd0, err_flag}, 64'd1);
    send(3'd6, 0, 0, 0, 0, pm); chk("R8 clear drops flag", {63'd0, err_flag}, 64'd0);
  endtask

  task automatic t_stall;
    @(negedge clk); resp_ready = 1'b0;
    send(3'd2, 0, 0, 0, 0, pm); chk("R9 stalled deny", {63'd0, pm}, 64'd0);
    req_valid = 1'b1; req_op = 3'd1; req_blk = BW'(1);
    #0.5; chk("R9 ready low while stalled", {63'd0, req_ready}, 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R9 response held", {62'd0, resp_valid, resp_permit}, 64'd2);
    blk_state(1, 1'b1, "R9 stalled request not taken");
    resp_ready = 1'b1;
    #0.5; chk("R9 ready when drained", {63'd0, req_ready}, 64'd1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R9 new response", {62'd0, resp_valid, resp_permit}, 64'd3);
    blk_state(1, 1'b0, "R9 request taken after drain");
    send(3'd6, 0, 0, 0, 0, pm);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_blocks;
    t_range;
    t_lockout;
    t_otp;
    t_factory;
    t_seal;
    t_err;
    t_stall;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule